// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from up to eight I/O devices and decides when a small processor core must leave its program to serve one of them. Software controls it through a few memory-mapped registers. These are the processor status word, whose bit 0 is the global interrupt enable. There is a saved copy of that word, a per-device enable mask, a read-only pending mask, and a table with one handler address per device.

The core reports each instruction as it retires, together with that instruction's address. The controller takes an interrupt only at that boundary, and only when global interrupts are on and at least one device is both pending and enabled. When several devices qualify, the lowest-numbered one wins. For one cycle the controller then raises a redirect strobe. It presents the winning device's table entry as the new program counter, the retired address plus 4 as the return point, and a one-hot acknowledge to the winner alone. On entry it saves the status word, clears the global enable and retires the winner's pending bit. A return-from-interrupt strobe from the core copies the saved word back into the status register, which turns interrupts on again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, the status, saved-status, enable and pending registers and all vector entries read 0, and irq_take, irq_ack, irq_vector and irq_return are 0.
- R2: A device whose enable bit (offset 8, bit i for device i) is 0 is never taken, even while its pending bit is set and global interrupts are on.
- R3: A high request line sets the device's pending bit on the next clock edge, whatever the enable bits and the global enable. The bit stays set until the device is acknowledged. Pending reads at offset 12 with bit i for device i, and bus writes to offset 12 have no effect.
- R4: An entry is decided on a clock edge where instr_done is 1, status bit 0 is 1, rti is 0 and at least one device is both pending and enabled. irq_take is then 1 for exactly the following cycle. With instr_done at 0, or with rti at 1, no entry is decided.
- R5: On entry, the saved-status register (offset 4) receives the whole status word as it stood. Status bit 0 becomes 0 and the other status bits are kept. A bus write to status or saved status on the same edge is dropped.
- R6: While irq_take is 1, irq_vector equals the vector entry of the chosen device, which is read and written at offset 16 + 4*i for device i.
- R7: Among qualifying devices the lowest index wins. irq_ack is one-hot on that device for the single irq_take cycle and 0 otherwise. Its pending bit clears on the entry edge while the other pending bits are kept.
- R8: While irq_take is 1, irq_return equals the instr_pc presented with the retiring instruction, plus 4.
- R9: While status bit 0 is 0, no entry is taken, but pending bits still set.
- R10: A cycle with rti at 1 loads the saved-status value into the status register, and this takes priority over a bus write to status.
- R11: Bus writes with bus_wr at 1 update status (offset 0), saved status (offset 4), enable (offset 8) and the vector entries. Reads on bus_rdata are combinational from bus_addr, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Request line per device |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| instr_done | input | 1 | An instruction retires this cycle |
| instr_pc | input | 32 | Address of the retiring instruction |
| rti | input | 1 | Return from interrupt: restore saved status |
| irq_take | output | 1 | One-cycle redirect strobe |
| irq_vector | output | 32 | Handler address while irq_take is 1 |
| irq_return | output | 32 | Return address while irq_take is 1 |
| irq_ack | output | NUM_SRC | One-hot acknowledge to the chosen device |

## Verification
The hardest state to reach is several devices pending at once while the handler of an earlier one still runs with interrupts off. Only in that state do priority, pending retention and the restore path interact. The stimulus pulses three request lines together during an idle stretch and holds off retirement so nothing is taken. It then drains the devices one at a time through entry and return pairs, including one cycle where retirement and return arrive together. A behavioural model with its own queues of state runs beside the design and is compared on every clock.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int DATA_W       = 32;
    localparam int BUS_AW       = 8;
    localparam int IE_BIT       = 0;
    localparam int PC_STEP      = 4;

    localparam int OFS_STATUS   = 0;
    localparam int OFS_SAVED    = 4;
    localparam int OFS_ENABLE   = 8;
    localparam int OFS_PENDING  = 12;
    localparam int OFS_VEC_BASE = 16;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_STATUS,
        RS_SAVED,
        RS_ENABLE,
        RS_PENDING,
        RS_VECTOR
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [BUS_AW-1:0]     vidx;
    } reg_hit_t;

    typedef struct packed {
        logic                  wr;
        logic [BUS_AW-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
    } bus_req_t;

    function automatic reg_hit_t decode_reg(input logic [BUS_AW-1:0] a, input int n_src);
        reg_hit_t hit;
        int       ofs;
        ofs      = int'(a);
        hit.sel  = RS_NONE;
        hit.vidx = '0;
        if (a[1:0] == 2'b00) begin
            if (ofs == OFS_STATUS)        hit.sel = RS_STATUS;
            else if (ofs == OFS_SAVED)    hit.sel = RS_SAVED;
            else if (ofs == OFS_ENABLE)   hit.sel = RS_ENABLE;
            else if (ofs == OFS_PENDING)  hit.sel = RS_PENDING;
            else if (ofs >= OFS_VEC_BASE && ofs < OFS_VEC_BASE + 4 * n_src) begin
                hit.sel  = RS_VECTOR;
                hit.vidx = BUS_AW'((ofs - OFS_VEC_BASE) >> 2);
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               any,
    output logic [NUM_SRC-1:0] grant,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
            assign grant[g]  = cand[g] & ~seen[g];
            assign seen[g+1] = seen[g] | cand[g];
        end
    endgenerate

    assign any = seen[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/ivc_pending.sv
module ivc_pending #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)          pend[g] <= 1'b0;
                else if (req[g])  pend[g] <= 1'b1;
                else if (clr[g])  pend[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           bus,
    input  logic               entry,
    input  logic               rti,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [IDX_W-1:0]   vec_idx,
    output logic [DATA_W-1:0]  status,
    output logic [DATA_W-1:0]  saved,
    output logic [NUM_SRC-1:0] enable,
    output logic [DATA_W-1:0]  vec_word,
    output logic [DATA_W-1:0]  rdata
);

    reg_hit_t          whit;
    reg_hit_t          rhit;
    logic [DATA_W-1:0] vtab [NUM_SRC];
    logic [DATA_W-1:0] ie_clear_mask;

    assign whit          = decode_reg(bus.addr, NUM_SRC);
    assign ie_clear_mask = ~(DATA_W'(1) << IE_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (entry) begin
            status <= status & ie_clear_mask;
        end else if (rti) begin
            status <= saved;
        end else if (bus.wr && whit.sel == RS_STATUS) begin
            status <= bus.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved <= '0;
        end else if (entry) begin
            saved <= status;
        end else if (bus.wr && whit.sel == RS_SAVED) begin
            saved <= bus.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (bus.wr && whit.sel == RS_ENABLE) begin
            enable <= bus.wdata[NUM_SRC-1:0];
        end
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
            always_ff @(posedge clk) begin
                if (rst) begin
                    vtab[g] <= '0;
                end else if (bus.wr && whit.sel == RS_VECTOR && int'(whit.vidx) == g) begin
                    vtab[g] <= bus.wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        vec_word = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(vec_idx) == i) vec_word = vtab[i];
        end
    end

    assign rhit = decode_reg(bus.addr, NUM_SRC);

    always_comb begin
        rdata = '0;
        case (rhit.sel)
            RS_STATUS:  rdata = status;
            RS_SAVED:   rdata = saved;
            RS_ENABLE:  rdata = DATA_W'(enable);
            RS_PENDING: rdata = DATA_W'(pend);
            RS_VECTOR: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (int'(rhit.vidx) == i) rdata = vtab[i];
                end
            end
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               instr_done,
    input  logic [DATA_W-1:0]  instr_pc,
    input  logic               rti,
    output logic               irq_take,
    output logic [DATA_W-1:0]  irq_vector,
    output logic [DATA_W-1:0]  irq_return,
    output logic [NUM_SRC-1:0] irq_ack
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    bus_req_t           bus;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] en_q;
    logic [DATA_W-1:0]  status_q;
    logic [DATA_W-1:0]  saved_q;
    logic [DATA_W-1:0]  vec_word;
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               any_cand;
    logic               go;
    logic [NUM_SRC-1:0] clr_mask;

    assign bus.wr    = bus_wr;
    assign bus.addr  = bus_addr;
    assign bus.wdata = bus_wdata;

    assign cand     = pend_q & en_q;
    assign go       = status_q[IE_BIT] & instr_done & any_cand & ~rti;
    assign clr_mask = go ? grant : '0;

    ivc_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .cand  (cand),
        .any   (any_cand),
        .grant (grant),
        .idx   (win_idx)
    );

    ivc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .req  (irq_req),
        .clr  (clr_mask),
        .pend (pend_q)
    );

    ivc_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .entry    (go),
        .rti      (rti),
        .pend     (pend_q),
        .vec_idx  (win_idx),
        .status   (status_q),
        .saved    (saved_q),
        .enable   (en_q),
        .vec_word (vec_word),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_take   <= 1'b0;
            irq_ack    <= '0;
            irq_vector <= '0;
            irq_return <= '0;
        end else begin
            irq_take   <= go;
            irq_ack    <= go ? grant : '0;
            irq_vector <= go ? vec_word : '0;
            irq_return <= go ? instr_pc + DATA_W'(PC_STEP) : '0;
        end
    end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [DATA_W-1:0]  instr_pc,
    input logic               rti,
    input logic               irq_take,
    input logic [DATA_W-1:0]  irq_return,
    input logic [NUM_SRC-1:0] irq_ack,
    input logic [DATA_W-1:0]  status,
    input logic [DATA_W-1:0]  saved,
    input logic [NUM_SRC-1:0] pending,
    input logic [NUM_SRC-1:0] enable
);

    a_r7_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));

    a_r7_ack_with_take: assert property (@(posedge clk) disable iff (rst)
        irq_take == (irq_ack != '0));

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take);

    a_r5_ie_cleared: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (!status[IE_BIT] && saved[IE_BIT]));

    a_r9_needs_ie: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> $past(status[IE_BIT]));

    a_r2_only_enabled: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> ((irq_ack & $past(enable)) != '0));

    a_r8_return_pc: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (irq_return == $past(instr_pc) + DATA_W'(PC_STEP)));

    a_r7_pending_cleared: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> ((pending & irq_ack) == ($past(irq_req) & irq_ack)));

    a_r10_restore: assert property (@(posedge clk) disable iff (rst)
        rti |=> (status == $past(saved)));

endmodule

bind irq_vector_ctrl ivc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .instr_pc   (instr_pc),
    .rti        (rti),
    .irq_take   (irq_take),
    .irq_return (irq_return),
    .irq_ack    (irq_ack),
    .status     (status_q),
    .saved      (saved_q),
    .pending    (pend_q),
    .enable     (en_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          instr_done = 1'b0;
    logic [31:0]   instr_pc = '0;
    logic          rti = 1'b0;
    logic          irq_take;
    logic [31:0]   irq_vector;
    logic [31:0]   irq_return;
    logic [N-1:0]  irq_ack;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    irq_vector_ctrl #(.NUM_SRC(N)) dut (.*);

    always #10 clk = ~clk;

    // behavioural reference state
    logic [31:0] m_status, m_saved, m_en, m_pend;
    logic [31:0] m_vec [N];
    logic        m_take;
    logic [31:0] m_ack, m_vpc, m_rpc;

    always @(posedge clk) begin
        logic [31:0] cand;
        int          win;
        bit          go;
        if (rst) begin
            m_status = 0; m_saved = 0; m_en = 0; m_pend = 0;
            foreach (m_vec[i]) m_vec[i] = 0;
            m_take = 0; m_ack = 0; m_vpc = 0; m_rpc = 0;
        end else begin
            cand = m_pend & m_en;
            win  = -1;
            for (int i = N - 1; i >= 0; i--) if (cand[i]) win = i;
            go = m_status[0] && instr_done && (win >= 0) && !rti;
            m_take = go;
            m_ack  = go ? (32'd1 << win) : 0;
            m_vpc  = go ? m_vec[win] : 0;
            m_rpc  = go ? instr_pc + 4 : 0;
            if (go) begin
                m_saved  = m_status;
                m_status = m_status & ~32'd1;
            end else begin
                if (rti) m_status = m_saved;
                else if (bus_wr && bus_addr == 0) m_status = bus_wdata;
                if (bus_wr && bus_addr == 4) m_saved = bus_wdata;
            end
            if (bus_wr && bus_addr == 8) m_en = bus_wdata & 32'hFF;
            for (int i = 0; i < N; i++)
                if (bus_wr && bus_addr == 8'(16 + 4 * i)) m_vec[i] = bus_wdata;
            m_pend = (m_pend & ~m_ack) | 32'(irq_req);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare against the model every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 model take", 32'(irq_take), 32'(m_take));
            chk("R7 model ack", 32'(irq_ack), m_ack);
            chk("R6 model vector", irq_vector, m_vpc);
            chk("R8 model return", irq_return, m_rpc);
        end
    end

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cycle();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic retire(input logic [31:0] pc);
        instr_done = 1'b1; instr_pc = pc;
        cycle();
        instr_done = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1;
        cycle();
        rti = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cycle();

        // R1 reset state
        rd("R1 status", 8'd0, 0);
        rd("R1 saved", 8'd4, 0);
        rd("R1 enable", 8'd8, 0);
        rd("R1 pending", 8'd12, 0);
        rd("R1 vector0", 8'd16, 0);
        chk("R1 take", 32'(irq_take), 0);
        chk("R1 ack", 32'(irq_ack), 0);

        // R11 register write and readback
        for (int i = 0; i < N; i++) wr(8'(16 + 4 * i), 32'h1000 + 32'(i) * 32'h40);
        for (int i = 0; i < N; i++) rd("R11 vector", 8'(16 + 4 * i), 32'h1000 + 32'(i) * 32'h40);
        wr(8'd4, 32'h0000_5A5A);
        rd("R11 saved", 8'd4, 32'h0000_5A5A);
        rd("R11 unmapped", 8'd48, 0);

        // R3 pending sets with everything disabled; writes to offset 12 ignored
        irq_req = 8'h08;
        cycle();
        irq_req = 8'h00;
        rd("R3 pending set", 8'd12, 32'h08);
        wr(8'd12, 32'h0);
        rd("R3 pending write ignored", 8'd12, 32'h08);

        // R2 disabled device never taken
        wr(8'd8, 32'hF7);
        wr(8'd0, 32'h0000_00A5);
        retire(32'h100);
        chk("R2 no take disabled", 32'(irq_take), 0);
        rd("R2 still pending", 8'd12, 32'h08);

        // R4 R5 R6 R8 entry
        wr(8'd8, 32'hFF);
        retire(32'h200);
        chk("R4 take", 32'(irq_take), 1);
        chk("R6 vector", irq_vector, 32'h10C0);
        chk("R8 return", irq_return, 32'h204);
        chk("R7 ack dev3", 32'(irq_ack), 32'h08);
        cycle();
        chk("R4 take one cycle", 32'(irq_take), 0);
        rd("R5 saved", 8'd4, 32'h0000_00A5);
        rd("R5 status ie cleared", 8'd0, 32'h0000_00A4);
        rd("R7 pending cleared", 8'd12, 0);

        // R9 global enable low: no entry, pending still sets
        irq_req = 8'h02;
        cycle();
        irq_req = 8'h00;
        retire(32'h300);
        chk("R9 no take ie low", 32'(irq_take), 0);
        rd("R9 pending sets", 8'd12, 32'h02);

        // R10 restore, then device 1 taken
        do_rti();
        rd("R10 status restored", 8'd0, 32'h0000_00A5);
        retire(32'h400);
        chk("R6 vector dev1", irq_vector, 32'h1040);
        chk("R7 ack dev1", 32'(irq_ack), 32'h02);
        do_rti();

        // R7 simultaneous requests, R4 no entry without retire
        irq_req = 8'h64;
        cycle();
        irq_req = 8'h00;
        cycle();
        chk("R4 no take without retire", 32'(irq_take), 0);
        retire(32'h500);
        chk("R7 lowest wins", 32'(irq_ack), 32'h04);
        chk("R6 vector dev2", irq_vector, 32'h1080);
        rd("R7 others kept", 8'd12, 32'h60);
        do_rti();

        // R4 rti with retire: no entry
        instr_done = 1'b1; instr_pc = 32'h600; rti = 1'b1;
        cycle();
        instr_done = 1'b0; rti = 1'b0;
        chk("R4 no take during rti", 32'(irq_take), 0);
        // R10 rti beats bus write to status
        rti = 1'b1; bus_wr = 1'b1; bus_addr = 8'd0; bus_wdata = 32'h0;
        cycle();
        rti = 1'b0; bus_wr = 1'b0;
        rd("R10 rti over write", 8'd0, 32'h0000_00A5);

        retire(32'h700);
        chk("R7 next dev5", 32'(irq_ack), 32'h20);
        chk("R8 return dev5", irq_return, 32'h704);
        do_rti();
        retire(32'h800);
        chk("R7 next dev6", 32'(irq_ack), 32'h40);
        chk("R6 vector dev6", irq_vector, 32'h1180);
        rd("R7 pending drained", 8'd12, 0);
        do_rti();
        cycle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule